// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block carries out the fixed state-save sequence a processor core runs once an interrupt has been granted. When the grant strobe arrives, it saves the current status word and the return program counter as a two-word frame on a downward-growing memory stack, one write at a time, through a simple request/ready port. It then reports a new status word with interrupts disabled and the mask field raised to the granted level, a stack pointer lowered by one frame, and the vector address as the next program counter. The three values come out together with a one-cycle done pulse.

A return request runs the opposite path. It reads the saved status word from the current stack pointer and the return address from the word above it. It then reports both, with the stack pointer raised by one frame. The sequencer accepts one request at a time and shows this with a busy flag. Status-word layout: the enable bit sits at position `IE_POS` (default 11), and the mask field is `LVL_W` bits wide starting at `IM_POS` (default bits 10..8). Stack addresses are byte addresses on word boundaries.

Top module: `irq_entry_seq`

## Requirements
- R1: After a grant, the first memory access is a write of the captured status word to address SP-8.
- R2: The second access is a write of the captured return PC to address SP-4. It begins only after the first write has seen ready.
- R3: After a maskable entry, `new_psw` equals the captured status word with bit 11 cleared and bits 10..8 set to the granted level. All other bits are unchanged.
- R4: In the cycle after the final write's ready, `done` pulses for one cycle, with `new_pc` equal to the captured vector and `new_sp` equal to SP-8.
- R5: While `mem_ready` is low, the request, direction, address and write data all hold steady.
- R6: `busy` is high from the cycle after a grant until the final handshake. A grant or return request that arrives while busy is ignored and does not change the outputs or the memory traffic.
- R7: On a return request, the block reads address SP and then SP+4. It then pulses `done` with `new_psw` equal to the first word read, `new_pc` equal to the second word read, and `new_sp` equal to SP+8.
- R8: After reset, `busy`, `done` and `mem_req` are low and `new_pc`, `new_psw` and `new_sp` are zero.
- R9: If a grant and a return request arrive in the same idle cycle, the grant is taken and the return request is dropped.
- R10: After a non-maskable entry, bit 11 of `new_psw` is cleared, and every bit outside bits 11..8 is preserved. The mask field is left unspecified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Interrupt grant strobe |
| acc_level | input | LVL_W | Granted priority level |
| acc_vector | input | XLEN | Handler start address |
| acc_nmi | input | 1 | Grant is non-maskable |
| rti_req | input | 1 | Return-from-interrupt request |
| cur_pc | input | XLEN | Return address to save |
| cur_psw | input | XLEN | Status word to save |
| cur_sp | input | XLEN | Current stack pointer, word aligned |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | XLEN | Byte address of the access |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Access completes at this clock edge |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: new state is valid |
| new_pc | output | XLEN | Program counter after the sequence |
| new_psw | output | XLEN | Status word after the sequence |
| new_sp | output | XLEN | Stack pointer after the sequence |

## Verification
The assertions assume a memory that eventually raises `mem_ready`, that returns read data in the same cycle as ready, and that sees word-aligned stack pointers that do not change while a request is pending. The bench's memory responder answers every request after a chosen wait of zero to three cycles. The stimulus uses only stack pointers that are multiples of four. It keeps `cur_*` stable from the grant until the next idle phase, and pulses grants and return requests during busy phases only to show that they are ignored.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_SR,
      ST_PUSH_RA,
      ST_POP_SR,
      ST_POP_RA
   } seq_state_e;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
   import irq_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc_valid,
   input  logic       rti_req,
   input  logic       mem_ready,
   output seq_state_e state,
   output logic       take_entry,
   output logic       take_rti,
   output logic       got_sr,
   output logic       fin_entry,
   output logic       fin_rti
);
   seq_state_e nxt;

   // grant wins over a simultaneous return request (R9)
   assign take_entry = (state == ST_IDLE) && acc_valid;
   assign take_rti   = (state == ST_IDLE) && !acc_valid && rti_req;
   assign got_sr     = (state == ST_POP_SR) && mem_ready;
   assign fin_entry  = (state == ST_PUSH_RA) && mem_ready;
   assign fin_rti    = (state == ST_POP_RA) && mem_ready;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: begin
            if (take_entry)    nxt = ST_PUSH_SR;
            else if (take_rti) nxt = ST_POP_SR;
         end
         ST_PUSH_SR: if (mem_ready) nxt = ST_PUSH_RA;
         ST_PUSH_RA: if (mem_ready) nxt = ST_IDLE;
         ST_POP_SR:  if (mem_ready) nxt = ST_POP_RA;
         ST_POP_RA:  if (mem_ready) nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/irq_seq_addr.sv
module irq_seq_addr
   import irq_seq_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  seq_state_e      state,
   input  logic [XLEN-1:0] sp_base,
   output logic            mem_req,
   output logic            mem_we,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] sp_entry,
   output logic [XLEN-1:0] sp_rti
);
   localparam logic [XLEN-1:0] WORD  = XLEN'(4);
   localparam logic [XLEN-1:0] FRAME = XLEN'(8);

   assign sp_entry = sp_base - FRAME;
   assign sp_rti   = sp_base + FRAME;

   always_comb begin
      mem_req  = 1'b1;
      mem_we   = 1'b0;
      mem_addr = sp_base;
      unique case (state)
         ST_PUSH_SR: begin mem_we = 1'b1; mem_addr = sp_base - FRAME; end
         ST_PUSH_RA: begin mem_we = 1'b1; mem_addr = sp_base - WORD;  end
         ST_POP_SR:  mem_addr = sp_base;
         ST_POP_RA:  mem_addr = sp_base + WORD;
         default:    mem_req = 1'b0;
      endcase
   end
endmodule

// File: rtl/irq_seq_psw.sv
module irq_seq_psw #(
   parameter int XLEN          = 32,
   parameter int LVL_W         = 3,
   parameter int IE_POS        = 11,
   parameter int IM_POS        = 8,
   parameter bit NMI_FULL_MASK = 1'b1
) (
   input  logic [XLEN-1:0]  psw_in,
   input  logic [LVL_W-1:0] level,
   input  logic             nmi,
   output logic [XLEN-1:0]  psw_out
);
   logic [LVL_W-1:0] im_val;

   generate
      if (NMI_FULL_MASK) begin : g_nmi_full
         assign im_val = nmi ? {LVL_W{1'b1}} : level;
      end else begin : g_nmi_keep
         assign im_val = nmi ? psw_in[IM_POS +: LVL_W] : level;
      end
   endgenerate

   always_comb begin
      psw_out                   = psw_in;
      psw_out[IE_POS]           = 1'b0;
      psw_out[IM_POS +: LVL_W]  = im_val;
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter int LVL_W         = 3,
   parameter int IE_POS        = 11,
   parameter int IM_POS        = 8,
   parameter bit NMI_FULL_MASK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [LVL_W-1:0] acc_level,
   input  logic [XLEN-1:0]  acc_vector,
   input  logic             acc_nmi,
   input  logic             rti_req,
   input  logic [XLEN-1:0]  cur_pc,
   input  logic [XLEN-1:0]  cur_psw,
   input  logic [XLEN-1:0]  cur_sp,
   output logic             mem_req,
   output logic             mem_we,
   output logic [XLEN-1:0]  mem_addr,
   output logic [XLEN-1:0]  mem_wdata,
   input  logic [XLEN-1:0]  mem_rdata,
   input  logic             mem_ready,
   output logic             busy,
   output logic             done,
   output logic [XLEN-1:0]  new_pc,
   output logic [XLEN-1:0]  new_psw,
   output logic [XLEN-1:0]  new_sp
);
   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("XLEN must be at least 8");
      end
      if (LVL_W < 1 || IM_POS + LVL_W > XLEN) begin : g_bad_im
         $error("mask field does not fit in the status word");
      end
      if (IE_POS >= XLEN || (IE_POS >= IM_POS && IE_POS < IM_POS + LVL_W)) begin : g_bad_ie
         $error("enable bit must lie inside the word and outside the mask field");
      end
   endgenerate

   seq_state_e       state;
   logic             take_entry, take_rti, got_sr, fin_entry, fin_rti;
   logic [XLEN-1:0]  sv_pc, sv_psw, sv_sp, sv_vec;
   logic [LVL_W-1:0] sv_lvl;
   logic             sv_nmi;
   logic [XLEN-1:0]  sp_entry, sp_rti, psw_entry;
   logic             done_r;

   irq_seq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .rti_req    (rti_req),
      .mem_ready  (mem_ready),
      .state      (state),
      .take_entry (take_entry),
      .take_rti   (take_rti),
      .got_sr     (got_sr),
      .fin_entry  (fin_entry),
      .fin_rti    (fin_rti)
   );

   irq_seq_addr #(.XLEN(XLEN)) u_addr (
      .state    (state),
      .sp_base  (sv_sp),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .sp_entry (sp_entry),
      .sp_rti   (sp_rti)
   );

   irq_seq_psw #(
      .XLEN(XLEN), .LVL_W(LVL_W), .IE_POS(IE_POS), .IM_POS(IM_POS),
      .NMI_FULL_MASK(NMI_FULL_MASK)
   ) u_psw (
      .psw_in  (sv_psw),
      .level   (sv_lvl),
      .nmi     (sv_nmi),
      .psw_out (psw_entry)
   );

   assign mem_wdata = (state == ST_PUSH_SR) ? sv_psw : sv_pc;
   assign busy      = (state != ST_IDLE);
   assign done      = done_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sv_pc   <= '0;
         sv_psw  <= '0;
         sv_sp   <= '0;
         sv_vec  <= '0;
         sv_lvl  <= '0;
         sv_nmi  <= 1'b0;
         new_pc  <= '0;
         new_psw <= '0;
         new_sp  <= '0;
         done_r  <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (take_entry) begin
            sv_pc  <= cur_pc;
            sv_psw <= cur_psw;
            sv_sp  <= cur_sp;
            sv_vec <= acc_vector;
            sv_lvl <= acc_level;
            sv_nmi <= acc_nmi;
         end
         if (take_rti) sv_sp  <= cur_sp;
         if (got_sr)   sv_psw <= mem_rdata;
         if (fin_entry) begin
            new_pc  <= sv_vec;
            new_psw <= psw_entry;
            new_sp  <= sp_entry;
            done_r  <= 1'b1;
         end
         if (fin_rti) begin
            new_pc  <= mem_rdata;
            new_psw <= sv_psw;
            new_sp  <= sp_rti;
            done_r  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
   parameter int XLEN   = 32,
   parameter int IE_POS = 11
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            done,
   input logic            mem_req,
   input logic            mem_we,
   input logic            mem_ready,
   input logic [XLEN-1:0] mem_addr,
   input logic [XLEN-1:0] mem_wdata,
   input logic [XLEN-1:0] new_psw,
   input logic [XLEN-1:0] new_sp
);
   localparam logic [XLEN-1:0] WORD = XLEN'(4);

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

   // R2 and R7: the second access of a pair is one word above the first
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready |=> !mem_req || (mem_addr == $past(mem_addr) + WORD && mem_we == $past(mem_we)));

   p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !(mem_req && mem_ready) |=> busy);

   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !mem_req);

   p_ie_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done && $past(mem_we) |-> !new_psw[IE_POS]);

   p_sp_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done && $past(mem_we) |-> new_sp == $past(mem_addr) - WORD);

   p_sp_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done && !$past(mem_we) |-> new_sp == $past(mem_addr) + WORD);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.XLEN(XLEN), .IE_POS(IE_POS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .new_psw   (new_psw),
   .new_sp    (new_sp)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_nmi = 1'b0, rti_req = 1'b0;
   logic [2:0]  acc_level = '0;
   logic [31:0] acc_vector = '0, cur_pc = '0, cur_psw = '0, cur_sp = '0;
   logic        mem_req, mem_we, mem_ready = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic        busy, done;
   logic [31:0] new_pc, new_psw, new_sp;

   always #2 clk = ~clk;

   irq_entry_seq u0 (.*);

   int n_cmp = 0, n_bad = 0;
   int lat = 0, wcnt = 0;
   logic [31:0] bmem [0:63];

   // reference model state
   int          m_ph = 0;
   logic [31:0] m_sp, m_pc, m_psw, m_vec, m_tmp;
   logic [2:0]  m_lvl;
   bit          m_nmi, e_done, e_rti, e_nmi;
   logic [31:0] e_pc = '0, e_psw = '0, e_sp = '0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int idx(logic [31:0] a);
      return int'(a[7:2]);
   endfunction

   // reference model and memory store, both at the active edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; e_done = 0; e_pc = '0; e_psw = '0; e_sp = '0;
      end else begin
         if (mem_req && mem_we && mem_ready) bmem[idx(mem_addr)] = mem_wdata;
         e_done = 0;
         case (m_ph)
            0: if (acc_valid) begin
                  m_sp = cur_sp; m_pc = cur_pc; m_psw = cur_psw;
                  m_vec = acc_vector; m_lvl = acc_level; m_nmi = acc_nmi; m_ph = 1;
               end else if (rti_req) begin
                  m_sp = cur_sp; m_ph = 3;
               end
            1: if (mem_ready) m_ph = 2;
            2: if (mem_ready) begin
                  e_pc = m_vec; e_sp = m_sp - 8;
                  e_psw = m_psw; e_psw[11] = 1'b0; e_psw[10:8] = m_lvl;
                  e_nmi = m_nmi; e_rti = 0; e_done = 1; m_ph = 0;
               end
            3: if (mem_ready) begin m_tmp = mem_rdata; m_ph = 4; end
            4: if (mem_ready) begin
                  e_pc = mem_rdata; e_psw = m_tmp; e_sp = m_sp + 8;
                  e_nmi = 0; e_rti = 1; e_done = 1; m_ph = 0;
               end
            default: m_ph = 0;
         endcase
      end
   end

   // per-cycle comparison, then the memory responder
   always @(negedge clk) begin
      if (rst_n) begin
         logic [31:0] ea, ew, mask;
         string ta;
         chk("R6 busy", 32'(busy), 32'(m_ph != 0));
         chk("R6 mem_req", 32'(mem_req), 32'(m_ph != 0));
         if (m_ph != 0) begin
            case (m_ph)
               1: begin ea = m_sp - 8; ew = m_psw; ta = "R1"; end
               2: begin ea = m_sp - 4; ew = m_pc;  ta = "R2"; end
               3: begin ea = m_sp;     ew = '0;    ta = "R7"; end
               default: begin ea = m_sp + 4; ew = '0; ta = "R7"; end
            endcase
            if (!mem_ready) ta = "R5";
            chk({ta, " addr"}, mem_addr, ea);
            chk({ta, " we"}, 32'(mem_we), 32'(m_ph <= 2));
            if (m_ph <= 2) chk({ta, " wdata"}, mem_wdata, ew);
         end
         chk("R4 done", 32'(done), 32'(e_done));
         chk(e_rti ? "R7 new_pc" : "R4 new_pc", new_pc, e_pc);
         chk(e_rti ? "R7 new_sp" : "R4 new_sp", new_sp, e_sp);
         mask = e_nmi ? 32'hFFFF_F8FF : 32'hFFFF_FFFF;
         chk(e_rti ? "R7 new_psw" : (e_nmi ? "R10 new_psw" : "R3 new_psw"),
             new_psw & mask, e_psw & mask);
      end
      if (!mem_req) begin
         mem_ready <= 1'b0; wcnt = 0;
      end else if (wcnt >= lat) begin
         mem_ready <= 1'b1; mem_rdata <= bmem[idx(mem_addr)]; wcnt = 0;
      end else begin
         mem_ready <= 1'b0; wcnt++;
      end
   end

   task automatic grant(logic [31:0] pc, psw, sp, vec, logic [2:0] lvl, logic nmi, logic also_rti);
      @(negedge clk);
      cur_pc = pc; cur_psw = psw; cur_sp = sp; acc_vector = vec;
      acc_level = lvl; acc_nmi = nmi; acc_valid = 1'b1; rti_req = also_rti;
      @(negedge clk);
      acc_valid = 1'b0; rti_req = 1'b0;
   endtask

   task automatic ret(logic [31:0] sp);
      @(negedge clk);
      cur_sp = sp; rti_req = 1'b1;
      @(negedge clk);
      rti_req = 1'b0;
   endtask

   task automatic settle();
      repeat (14) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) bmem[i] = 32'hA5A5_0000 + 32'(i);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 busy", 32'(busy), 32'd0);
      chk("R8 done", 32'(done), 32'd0);
      chk("R8 mem_req", 32'(mem_req), 32'd0);
      chk("R8 new_pc", new_pc, 32'd0);
      chk("R8 new_psw", new_psw, 32'd0);
      chk("R8 new_sp", new_sp, 32'd0);

      // maskable entry, no wait states
      lat = 0;
      grant(32'h1000_0040, 32'h0000_08F0, 32'h0000_0100, 32'h4000_1234, 3'd3, 1'b0, 1'b0);
      settle();
      chk("R1 saved psw", bmem[idx(32'h0F8)], 32'h0000_08F0);
      chk("R2 saved pc", bmem[idx(32'h0FC)], 32'h1000_0040);
      chk("R3 psw after entry", new_psw, 32'h0000_03F0);
      chk("R4 pc after entry", new_pc, 32'h4000_1234);
      chk("R4 sp after entry", new_sp, 32'h0000_00F8);

      // return restores the frame just pushed
      lat = 1;
      ret(32'h0000_00F8);
      settle();
      chk("R7 restored pc", new_pc, 32'h1000_0040);
      chk("R7 restored psw", new_psw, 32'h0000_08F0);
      chk("R7 restored sp", new_sp, 32'h0000_0100);

      // wait states plus stray requests while busy
      lat = 2;
      grant(32'h2000_0000, 32'h0000_0800, 32'h0000_0080, 32'h4000_0400, 3'd5, 1'b0, 1'b0);
      acc_valid = 1'b1; acc_vector = 32'h4000_FFFC; acc_level = 3'd1;
      rti_req = 1'b1; cur_sp = 32'h0000_0040;
      @(negedge clk);
      acc_valid = 1'b0; rti_req = 1'b0;
      settle();
      chk("R6 ignored grant pc", new_pc, 32'h4000_0400);
      chk("R6 ignored grant sp", new_sp, 32'h0000_0078);
      chk("R5 psw after waited entry", new_psw, 32'h0000_0500);

      // simultaneous grant and return
      lat = 0;
      grant(32'h3000_0010, 32'h0000_0A00, 32'h0000_00C0, 32'h4000_0800, 3'd2, 1'b0, 1'b1);
      settle();
      chk("R9 grant wins pc", new_pc, 32'h4000_0800);
      chk("R9 grant wins sp", new_sp, 32'h0000_00B8);

      // non-maskable entry
      lat = 3;
      grant(32'h5000_0000, 32'hC3C3_0F0F, 32'h0000_0040, 32'h4000_0010, 3'd6, 1'b1, 1'b0);
      settle();
      chk("R10 ie cleared", 32'(new_psw[11]), 32'd0);
      chk("R10 other bits", new_psw & 32'hFFFF_F0FF, 32'hC3C3_0F0F & 32'hFFFF_F0FF);
      chk("R10 sp", new_sp, 32'h0000_0038);

      // mixed levels, latencies and a wrapping stack pointer
      for (int i = 0; i < 8; i++) begin
         lat = i % 4;
         grant(32'h0100_0000 + 32'(i * 16), 32'h0000_0800 | 32'(i), 32'hFFFF_FF00 - 32'(i * 16),
               32'h4000_2000 + 32'(i * 4), 3'(i), 1'b0, 1'b0);
         settle();
         ret(new_sp);
         settle();
      end
      ret(32'h0000_0000);
      settle();

      summary();
      $finish;
   end
endmodule